// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block is a small timer with four independent 16-bit channels behind a 16-bit register bus. Each channel has its own prescaled up-counter and four compare registers. It also holds a control word, a mode word, a pin-control word, and two plain storage words for interrupt enable and status. A shared run register at byte offset 0x00 starts and stops the channels, one bit per channel. Software changes a single channel by reading the register, changing the bit and writing it back.

In PWM mode a selected compare register clears the counter. Each channel drives one output pin. The pin rests at the level named in the pin-control word and takes a new level when the counter matches compare A. At the clearing match it returns to the resting level. Software drives a fixed level by writing a pin-control word whose action is "hold", with the channel running or stopped.

The bus is a plain register port with no handshake. A write commits on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr` and has no side effects. No data stream crosses the block edge, so there is no valid/ready back-pressure.

Top module: `cmpwm_timer`

## Requirements
- R1: After reset the run register, every channel register, every counter and every pin are 0.
- R2: Channel n's bank starts at byte 0x10 + n*0x40. Its offsets are: control 0x00, mode 0x04, pin control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, and compare A/B/C/D at 0x18/0x1C/0x20/0x24. Each register reads back the value last written. Interrupt enable and status are plain storage. Any other offset reads 0.
- R3: Bit n of the run register at 0x00 runs channel n. Bits at and above the channel count are ignored and read as 0.
- R4: Control bits [2:0] pick the tick divider: code c in 0..3 divides by 4^c, and codes 4..7 divide by 64. The divider restarts on every control write, so a channel running after a control write at edge W steps its counter at edges W+D, W+2D and so on.
- R5: Control bits [7:5] pick the clearing match: 1 is A, 2 is B, 5 is C and 6 is D. Any other code never clears, and the counter wraps. On a tick where the counter equals the selected compare value, the counter goes to 0.
- R6: In PWM mode (mode bits [1:0] = 2) the pin holds the resting level (pin control bit 2) while the count is 0..A. It takes the action level while the count is A+1..clear value, and returns to rest on the clearing tick. Resting 0 with action "set" gives low then high. Resting 1 with action "clear" gives high then low.
- R7: With compare A = 0, the action level begins one tick after the counter clears.
- R8: Pin control bits [1:0] give the action on a compare-A tick: 0 hold, 1 drive 0, 2 drive 1, 3 toggle. In normal mode (mode bits [1:0] other than 2) the clearing match does not restore the resting level.
- R9: A write to pin control sets the pin to bit 2 on that edge. A stopped channel's pin does not move otherwise.
- R10: A counter write takes effect on its edge. Clearing the run bit freezes the count, and setting it again resumes from the held value. A counter write alone never moves the pin.
- R11: Mode bits 4 to 6 and control bits [4:3] are stored and read back but do not change the waveform.
- R12: Channels are independent: one channel's registers, run bit and ticks never change another channel's pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, commits on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One output pin per channel |

## Verification
The hardest state to reach is a channel whose pin level disagrees with its counter. The pin changes only on match events, so after a counter write the waveform cannot be derived from the count alone. The bench freezes a running PWM channel mid-period, reads the frozen count, writes a new count past compare A and resumes. It then expects the pin to stay low until the next clear and the next compare-A tick. Prescaler phase is reached by writing the control word one cycle before setting the run bit. The counter is read on the exact cycles the divider predicts for divide-by-4 and the saturated code 7.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;
  localparam int BANK_BASE   = 'h10;
  localparam int BANK_STRIDE = 'h40;
  localparam int NCMP        = 4;

  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_MODE = 6'h04;
  localparam logic [5:0] OFF_PINC = 6'h08;
  localparam logic [5:0] OFF_IEN  = 6'h0C;
  localparam logic [5:0] OFF_STAT = 6'h10;
  localparam logic [5:0] OFF_CNT  = 6'h14;
  localparam logic [5:0] OFF_CMPA = 6'h18;

  localparam logic [1:0] MODE_PWM = 2'd2;

  // returns {valid, compare index}
  function automatic logic [2:0] clr_decode(input logic [2:0] code);
    case (code)
      3'd1:    clr_decode = 3'b100;
      3'd2:    clr_decode = 3'b101;
      3'd5:    clr_decode = 3'b110;
      3'd6:    clr_decode = 3'b111;
      default: clr_decode = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/cmpwm_prescale.sv
module cmpwm_prescale #(
  parameter int NPS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic [$clog2(NPS)-1:0] code,
  output logic                   tick
);
  localparam int DIVW = 2 * (NPS - 1);

  logic [DIVW-1:0] div_q;
  logic [DIVW:0]   full;
  logic [DIVW-1:0] mask;

  always_comb begin
    full = (DIVW+1)'(1) << (2 * code);
    mask = DIVW'(full - 1'b1);
    tick = &(div_q | ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cmpwm_channel.sv
module cmpwm_channel
  import cmpwm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NPS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_en,
  input  logic [5:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pin
);
  localparam int PSW = $clog2(NPS);

  logic [DW-1:0] ctrl_q, mode_q, pinc_q, ien_q, stat_q, cnt_q;
  logic [DW-1:0] cmp_q [NCMP];
  logic [NCMP-1:0] hit;
  logic [2:0]      clr_sel;
  logic            clr_hit, tick, step, pwm_mode, pin_q;
  logic [PSW-1:0]  ps_code;

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign hit[i] = (cnt_q == cmp_q[i]);
  end

  always_comb begin
    clr_sel  = clr_decode(ctrl_q[7:5]);
    clr_hit  = clr_sel[2] && hit[clr_sel[1:0]];
    pwm_mode = (mode_q[1:0] == MODE_PWM);
    step     = run && tick;
    if (ctrl_q[2:0] > 3'(NPS - 1)) ps_code = PSW'(NPS - 1);
    else                           ps_code = ctrl_q[PSW-1:0];
  end

  cmpwm_prescale #(.NPS(NPS)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_en && off == OFF_CTRL),
    .code    (ps_code),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; mode_q <= '0; pinc_q <= '0;
      ien_q  <= '0; stat_q <= '0; cnt_q  <= '0;
      pin_q  <= 1'b0;
      for (int i = 0; i < NCMP; i++) cmp_q[i] <= '0;
    end else begin
      if (wr_en && off == OFF_CTRL) ctrl_q <= wdata;
      if (wr_en && off == OFF_MODE) mode_q <= wdata;
      if (wr_en && off == OFF_PINC) pinc_q <= wdata;
      if (wr_en && off == OFF_IEN)  ien_q  <= wdata;
      if (wr_en && off == OFF_STAT) stat_q <= wdata;
      for (int i = 0; i < NCMP; i++)
        if (wr_en && off == 6'(OFF_CMPA + 4 * i)) cmp_q[i] <= wdata;

      if (wr_en && off == OFF_CNT) cnt_q <= wdata;
      else if (step)               cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;

      if (wr_en && off == OFF_PINC) pin_q <= wdata[2];
      else if (step) begin
        if (clr_hit && pwm_mode) pin_q <= pinc_q[2];
        else if (hit[0]) begin
          case (pinc_q[1:0])
            2'd1:    pin_q <= 1'b0;
            2'd2:    pin_q <= 1'b1;
            2'd3:    pin_q <= ~pin_q;
            default: pin_q <= pin_q;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_CTRL: rdata = ctrl_q;
      OFF_MODE: rdata = mode_q;
      OFF_PINC: rdata = pinc_q;
      OFF_IEN:  rdata = ien_q;
      OFF_STAT: rdata = stat_q;
      OFF_CNT:  rdata = cnt_q;
      default:  rdata = '0;
    endcase
    for (int i = 0; i < NCMP; i++)
      if (off == 6'(OFF_CMPA + 4 * i)) rdata = cmp_q[i];
  end

  assign pin = pin_q;
endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
  import cmpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NPS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int BW = AW - 6;

  logic [NCH-1:0] run_q;
  logic [AW-1:0]  rel;
  logic           in_banks;
  logic [BW-1:0]  bank;
  logic [5:0]     off;
  logic [DW-1:0]  ch_rd [NCH];

  always_comb begin
    rel      = bus_addr - AW'(BANK_BASE);
    in_banks = (bus_addr >= AW'(BANK_BASE));
    bank     = rel[AW-1:6];
    off      = rel[5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           run_q <= '0;
    else if (bus_we && bus_addr == '0)    run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cmpwm_channel #(.DW(DW), .NPS(NPS)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q[c]),
      .wr_en (bus_we && in_banks && bank == BW'(c)),
      .off   (off),
      .wdata (bus_wdata),
      .rdata (ch_rd[c]),
      .pin   (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = DW'(run_q);
    else if (in_banks)
      for (int c = 0; c < NCH; c++)
        if (bank == BW'(c)) bus_rdata = ch_rd[c];
  end
endmodule

// File: rtl/cmpwm_chk.sv
module cmpwm_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [NCH-1:0] wr_run,
  input logic           wr_lvl,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] pwm_out
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (run == '0 && pwm_out == '0));

  p_run_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |=> (run == $past(wr_run)));

  p_gap_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != '0 && bus_addr < AW'(16)) |-> (bus_rdata == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_pin
    logic pinc_wr;
    assign pinc_wr = bus_we && (bus_addr == AW'(16 + c * 64 + 8));

    p_pinc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pinc_wr |=> (pwm_out[c] == $past(wr_lvl)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !pinc_wr) |=> $stable(pwm_out[c]));
  end
endmodule

bind cmpwm_timer cmpwm_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .wr_run    (bus_wdata[NCH-1:0]),
  .wr_lvl    (bus_wdata[2]),
  .bus_rdata (bus_rdata),
  .run       (run_q),
  .pwm_out   (pwm_out)
);

// File: tb/cmpwm_timer_tb_top.sv
module cmpwm_timer_tb_top;
  localparam int NCH = 4;
  localparam int O_CTRL = 'h00, O_MODE = 'h04, O_PINC = 'h08, O_IEN = 'h0C;
  localparam int O_STAT = 'h10, O_CNT = 'h14, O_A = 'h18, O_B = 'h1C, O_C = 'h20, O_D = 'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int total = 0;
  int bad = 0;
  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  always #5 clk = ~clk;

  cmpwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] ra(input int ch, input int o);
    return 8'(16 + ch * 64 + o);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic push(input logic [NCH-1:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) begin
        logic [NCH-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (pwm_out !== e) begin
          bad++;
          $display("FAIL %s pins actual=%b expected=%b", t, pwm_out, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", 16'(pwm_out), 16'h0);
    rdchk("R1 run reg", 8'h00, 16'h0);
    rdchk("R1 counter", ra(0, O_CNT), 16'h0);

    // R2 map and storage, R3 run bits beyond channel count
    wr(ra(2, O_IEN), 16'h1234);
    wr(ra(3, O_STAT), 16'hBEEF);
    wr(ra(1, O_D), 16'h0F0F);
    rdchk("R2 ien", ra(2, O_IEN), 16'h1234);
    rdchk("R2 stat", ra(3, O_STAT), 16'hBEEF);
    rdchk("R2 cmpD", ra(1, O_D), 16'h0F0F);
    rdchk("R2 gap", 8'h06, 16'h0);
    rdchk("R2 bad offset", ra(0, 'h28), 16'h0);
    wr(8'h00, 16'hFFF0);
    rdchk("R3 upper run bits", 8'h00, 16'h0);

    // R6 PWM rest 0 / set, with R11 extra bits
    wr(ra(0, O_CTRL), 16'h0048);
    wr(ra(0, O_MODE), 16'h0072);
    wr(ra(0, O_PINC), 16'h0002);
    wr(ra(0, O_A), 16'd1);
    wr(ra(0, O_B), 16'd4);
    rdchk("R11 mode stored", ra(0, O_MODE), 16'h0072);
    rdchk("R11 ctrl stored", ra(0, O_CTRL), 16'h0048);
    wr(8'h00, 16'h0001);
    for (int k = 1; k <= 15; k++) begin
      v = '0; v[0] = ((k % 5) > 1);
      push(v, "R6 R11");
    end
    drain();

    // R10 freeze, counter write, resume
    wr(8'h00, 16'h0000);
    rdchk("R10 frozen", ra(0, O_CNT), 16'd1);
    repeat (5) @(negedge clk);
    rdchk("R10 still frozen", ra(0, O_CNT), 16'd1);
    chk("R9 stopped pin", 16'(pwm_out), 16'h0);
    wr(ra(0, O_CNT), 16'd3);
    rdchk("R10 counter write", ra(0, O_CNT), 16'd3);
    wr(8'h00, 16'h0001);
    push(4'b0000, "R10"); push(4'b0000, "R10"); push(4'b0000, "R10");
    push(4'b0001, "R10"); push(4'b0001, "R10"); push(4'b0001, "R10");
    drain();
    wr(8'h00, 16'h0000);

    // R7 compare A = 0, rest 1 / clear, R9 load on write
    wr(ra(0, O_PINC), 16'h0000);
    wr(ra(1, O_CTRL), 16'h0040);
    wr(ra(1, O_MODE), 16'h0002);
    wr(ra(1, O_A), 16'd0);
    wr(ra(1, O_B), 16'd3);
    wr(ra(1, O_PINC), 16'h0005);
    chk("R9 load on write", 16'(pwm_out), 16'h0002);
    wr(8'h00, 16'h0002);
    for (int k = 1; k <= 12; k++) begin
      v = '0; v[1] = ((k % 4) == 0);
      push(v, "R7 R6 R12");
    end
    drain();
    wr(8'h00, 16'h0000);
    wr(ra(1, O_PINC), 16'h0000);

    // R8 toggle in normal mode on ch2, hold on ch3
    wr(ra(2, O_CTRL), 16'h0040);
    wr(ra(2, O_MODE), 16'h0000);
    wr(ra(2, O_A), 16'd1);
    wr(ra(2, O_B), 16'd2);
    wr(ra(2, O_PINC), 16'h0003);
    wr(ra(3, O_CTRL), 16'h0040);
    wr(ra(3, O_MODE), 16'h0002);
    wr(ra(3, O_A), 16'd1);
    wr(ra(3, O_B), 16'd2);
    wr(ra(3, O_PINC), 16'h0004);
    wr(8'h00, 16'h000C);
    for (int k = 1; k <= 12; k++) begin
      v = '0; v[3] = 1'b1; v[2] = (((k + 1) / 3) % 2) == 1;
      push(v, "R8 R12");
    end
    drain();
    wr(8'h00, 16'h0000);

    // R5 clear on compare C, then a never-clear code
    wr(ra(0, O_CTRL), 16'h00A0);
    wr(ra(0, O_MODE), 16'h0000);
    wr(ra(0, O_C), 16'd2);
    wr(ra(0, O_B), 16'd1);
    wr(ra(0, O_CNT), 16'd0);
    wr(8'h00, 16'h0001);
    @(negedge clk); rdchk("R5 clear C k1", ra(0, O_CNT), 16'd1);
    @(negedge clk); rdchk("R5 clear C k2", ra(0, O_CNT), 16'd2);
    @(negedge clk); rdchk("R5 clear C k3", ra(0, O_CNT), 16'd0);
    wr(8'h00, 16'h0000);
    wr(ra(0, O_CTRL), 16'h0060);
    wr(ra(0, O_CNT), 16'd0);
    wr(8'h00, 16'h0001);
    repeat (5) @(negedge clk);
    rdchk("R5 no clear", ra(0, O_CNT), 16'd5);

    // R4 divide by 4
    wr(8'h00, 16'h0000);
    wr(ra(0, O_CNT), 16'd0);
    wr(ra(0, O_CTRL), 16'h0001);
    wr(8'h00, 16'h0001);
    repeat (2) @(negedge clk); rdchk("R4 div4 W+3", ra(0, O_CNT), 16'd0);
    @(negedge clk);            rdchk("R4 div4 W+4", ra(0, O_CNT), 16'd1);
    repeat (3) @(negedge clk); rdchk("R4 div4 W+7", ra(0, O_CNT), 16'd1);
    @(negedge clk);            rdchk("R4 div4 W+8", ra(0, O_CNT), 16'd2);

    // R4 code 7 saturates to divide by 64
    wr(8'h00, 16'h0000);
    wr(ra(0, O_CNT), 16'd0);
    wr(ra(0, O_CTRL), 16'h0007);
    wr(8'h00, 16'h0001);
    repeat (62) @(negedge clk); rdchk("R4 code7 W+63", ra(0, O_CNT), 16'd0);
    @(negedge clk);             rdchk("R4 code7 W+64", ra(0, O_CNT), 16'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule